// File: doc/BRIEF.md
# Radix-2 Word-Serial Montgomery Processing Element

This block is one stage of a systolic radix-2 Montgomery multiplier. The stage handles one multiplier bit x_i per column. The multiplicand Y, the modulus M and the running partial sum S arrive as a stream of w-bit words, least significant word first, one word per cycle. On the first word of a column the stage fixes the quotient bit q_i. For every word it then adds x_i·Y, q_i·M, the incoming S word and a two-bit carry. The words of the new sum leave shifted right by one bit, because the overall step divides by two.

A shifted output word needs the lowest bit of the word above it. Each output word therefore leaves one cycle after that higher word has been computed. The top word takes its high bit from the final carry. Y, M, x_i and q_i travel with the output words at the same delay, so a chain of identical stages can be built. An array controller feeds the first stage, the operands are loaded elsewhere, and the final subtraction is done elsewhere.

Top module: `mm_radix2_pe`

## Requirements
- R1: With operand width n and word width w, a column is e = ceil((n+1)/w) input words on consecutive cycles. The first word is marked by `in_first`. Each column yields exactly e output words, and only the first of them carries `out_first`.
- R2: The quotient bit is q = (x AND bit 0 of Y word 0) XOR (bit 0 of S word 0). It is taken on the first word and shown on `out_q` for every output word of the column.
- R3: The carry passed between words never exceeds 3. When S < 2M and Y < M, the carry left after the last word is at most 1.
- R4: Output word k (k = 0 is the lowest) is bits [k·w+w−1 : k·w] of (S + x·Y + q·M) / 2. The top bit of the last word comes from the final carry.
- R5: Each output word appears two cycles after the input word of the same index, and `out_valid` is high in that cycle. `out_y` and `out_m` carry that input word's Y and M with the same two-cycle delay.
- R6: The x bit is sampled only on the first word of a column. Values on `in_x` during the other words have no effect. The sampled x is shown on `out_x` for every output word of the column.
- R7: A new column may start in the cycle right after the last word of the previous one. Both columns then produce correct results.
- R8: While reset is high, and in the cycle after it, `out_valid`, `out_first` and `out_s` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input word is present |
| in_first | input | 1 | The present word is word 0 of a column |
| in_x | input | 1 | Multiplier bit, sampled on word 0 |
| in_y | input | WORD_W | Multiplicand word |
| in_m | input | WORD_W | Modulus word |
| in_s | input | WORD_W | Incoming partial-sum word |
| out_valid | output | 1 | An output word is present |
| out_first | output | 1 | The output word is word 0 of a column |
| out_x | output | 1 | Multiplier bit used for this column |
| out_q | output | 1 | Quotient bit decided for this column |
| out_y | output | WORD_W | Forwarded multiplicand word |
| out_m | output | WORD_W | Forwarded modulus word |
| out_s | output | WORD_W | Right-shifted new partial-sum word |

## Verification
The hardest case is when the last word of a column is still waiting for its high bit from the carry while the next column's word 0 is already entering. In that cycle the carry register is overwritten. The bench gets there by sending several columns with no idle cycle between them, both as directed cases and as part of a random run whose inter-column gap is often zero. The carry is also pushed to its bound by directed operands with Y = M−1 and S = 2M−1. The x-ignored rule is exercised by driving the inverted x bit on every word after the first.

// File: rtl/mm_pe_pkg.sv
package mm_pe_pkg;

  localparam int CARRY_W = 2;

  // number of words needed to hold a value of op_bits+1 bits
  function automatic int word_count(input int op_bits, input int word_w);
    return (op_bits + word_w) / word_w;
  endfunction

endpackage

// File: rtl/mm_word_acc.sv
module mm_word_acc
  import mm_pe_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic               x_bit,
  input  logic               q_bit,
  input  logic [CARRY_W-1:0] c_in,
  input  logic [WORD_W-1:0]  y_word,
  input  logic [WORD_W-1:0]  m_word,
  input  logic [WORD_W-1:0]  s_word,
  output logic [WORD_W-1:0]  s_out,
  output logic [CARRY_W-1:0] c_out
);

  localparam int SUM_W = WORD_W + CARRY_W;

  logic [SUM_W-1:0] total;

  always_comb begin
    total = SUM_W'(c_in)
          + (x_bit ? SUM_W'(y_word) : '0)
          + (q_bit ? SUM_W'(m_word) : '0)
          + SUM_W'(s_word);
    s_out = total[WORD_W-1:0];
    c_out = total[SUM_W-1:WORD_W];
  end

endmodule

// File: rtl/mm_qbit.sv
module mm_qbit (
  input  logic x_bit,
  input  logic y_lsb,
  input  logic s_lsb,
  output logic q_bit
);

  // makes the low bit of S + x*Y + q*M even
  assign q_bit = (x_bit & y_lsb) ^ s_lsb;

endmodule

// File: rtl/mm_fwd_pipe.sv
module mm_fwd_pipe #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             vld_out,
  output logic [WIDTH-1:0] data_out
);

  logic [DEPTH-1:0]            vld_r;
  logic [DEPTH-1:0][WIDTH-1:0] dat_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_r <= '0;
      dat_r <= '0;
    end else begin
      for (int k = DEPTH - 1; k > 0; k--) begin
        vld_r[k] <= vld_r[k-1];
        dat_r[k] <= dat_r[k-1];
      end
      vld_r[0] <= vld_in;
      dat_r[0] <= data_in;
    end
  end

  assign vld_out  = vld_r[DEPTH-1];
  assign data_out = dat_r[DEPTH-1];

endmodule

// File: rtl/mm_shift_out.sv
module mm_shift_out #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic              msb_in,
  input  logic [WORD_W-2:0] prev_hi,
  output logic [WORD_W-1:0] out_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
    end else if (emit) begin
      out_word <= {msb_in, prev_hi};
    end
  end

endmodule

// File: rtl/mm_radix2_pe.sv
module mm_radix2_pe
  import mm_pe_pkg::*;
#(
  parameter int OP_BITS = 16,
  parameter int WORD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_x,
  input  logic [WORD_W-1:0] in_y,
  input  logic [WORD_W-1:0] in_m,
  input  logic [WORD_W-1:0] in_s,
  output logic              out_valid,
  output logic              out_first,
  output logic              out_x,
  output logic              out_q,
  output logic [WORD_W-1:0] out_y,
  output logic [WORD_W-1:0] out_m,
  output logic [WORD_W-1:0] out_s
);

  localparam int NUM_WORDS = word_count(OP_BITS, WORD_W);
  localparam int CNT_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int FWD_W     = 3 + 2 * WORD_W;
  localparam int FWD_DEPTH = 2;

  // column state
  logic               x_q;
  logic               q_q;
  logic [CARRY_W-1:0] carry_q;
  logic [WORD_W-2:0]  sprev_hi;
  logic               flush_pend;
  logic [CNT_W-1:0]   cnt_q;

  // per-word datapath
  logic               q_new;
  logic               x_use;
  logic               q_use;
  logic [CARRY_W-1:0] c_in;
  logic [WORD_W-1:0]  sum_w;
  logic [CARRY_W-1:0] c_out;
  logic               is_last;
  logic               emit_word;
  logic               emit_hi;

  mm_qbit u_qbit (
    .x_bit (in_x),
    .y_lsb (in_y[0]),
    .s_lsb (in_s[0]),
    .q_bit (q_new)
  );

  always_comb begin
    x_use   = in_first ? in_x  : x_q;
    q_use   = in_first ? q_new : q_q;
    c_in    = in_first ? '0    : carry_q;
    is_last = in_first ? (NUM_WORDS == 1) : (cnt_q == CNT_W'(NUM_WORDS - 1));
  end

  mm_word_acc #(.WORD_W(WORD_W)) u_acc (
    .x_bit  (x_use),
    .q_bit  (q_use),
    .c_in   (c_in),
    .y_word (in_y),
    .m_word (in_m),
    .s_word (in_s),
    .s_out  (sum_w),
    .c_out  (c_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q        <= 1'b0;
      q_q        <= 1'b0;
      carry_q    <= '0;
      sprev_hi   <= '0;
      flush_pend <= 1'b0;
      cnt_q      <= '0;
    end else begin
      flush_pend <= in_valid && is_last;
      if (in_valid) begin
        carry_q  <= c_out;
        sprev_hi <= sum_w[WORD_W-1:1];
        cnt_q    <= in_first ? CNT_W'(1) : cnt_q + CNT_W'(1);
        if (in_first) begin
          x_q <= in_x;
          q_q <= q_new;
        end
      end
    end
  end

  // a shifted word leaves once the lsb of the word above is known;
  // the top word borrows its msb from the final carry
  always_comb begin
    emit_word = flush_pend || (in_valid && !in_first);
    emit_hi   = flush_pend ? carry_q[0] : sum_w[0];
  end

  mm_shift_out #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .emit     (emit_word),
    .msb_in   (emit_hi),
    .prev_hi  (sprev_hi),
    .out_word (out_s)
  );

  logic [FWD_W-1:0] fwd_in;
  logic [FWD_W-1:0] fwd_out;

  assign fwd_in = {in_first, x_use, q_use, in_y, in_m};

  mm_fwd_pipe #(.WIDTH(FWD_W), .DEPTH(FWD_DEPTH)) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .vld_in   (in_valid),
    .data_in  (fwd_in),
    .vld_out  (out_valid),
    .data_out (fwd_out)
  );

  assign out_first = fwd_out[FWD_W-1];
  assign out_x     = fwd_out[FWD_W-2];
  assign out_q     = fwd_out[FWD_W-3];
  assign out_y     = fwd_out[2*WORD_W-1:WORD_W];
  assign out_m     = fwd_out[WORD_W-1:0];

endmodule

// File: rtl/mm_radix2_pe_chk.sv
module mm_radix2_pe_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_first,
  input logic       out_valid,
  input logic       out_first,
  input logic       out_q,
  input logic       flush_pend,
  input logic [1:0] carry_q
);

  // R5: every accepted word shows up two cycles later
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R1: a column start reappears as a marked first output word
  assert_first_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |-> ##2 out_first);

  // R3: the carry left after the last word fits in one bit
  assert_final_carry_R3: assert property (@(posedge clk) disable iff (rst)
    flush_pend |-> (carry_q[1] == 1'b0));

  // R2: the quotient bit holds across the words of a column
  assert_q_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> $stable(out_q));

  // R8: reset clears the output strobes
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_first));

endmodule

bind mm_radix2_pe mm_radix2_pe_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_first   (in_first),
  .out_valid  (out_valid),
  .out_first  (out_first),
  .out_q      (out_q),
  .flush_pend (flush_pend),
  .carry_q    (carry_q)
);

// File: tb/mm_radix2_pe_tb_top.sv
`timescale 1ns/1ps
module mm_radix2_pe_tb_top;

  localparam int OP_BITS   = 16;
  localparam int WORD_W    = 4;
  localparam int NUM_WORDS = (OP_BITS + WORD_W) / WORD_W;
  localparam longint unsigned WMASK = (64'd1 << WORD_W) - 1;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid, in_first, in_x;
  logic [WORD_W-1:0] in_y, in_m, in_s;
  logic              out_valid, out_first, out_x, out_q;
  logic [WORD_W-1:0] out_y, out_m, out_s;

  always #4 clk = ~clk;

  mm_radix2_pe #(.OP_BITS(OP_BITS), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_x(in_x),
    .in_y(in_y), .in_m(in_m), .in_s(in_s), .out_valid(out_valid),
    .out_first(out_first), .out_x(out_x), .out_q(out_q), .out_y(out_y),
    .out_m(out_m), .out_s(out_s)
  );

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  longint      cyc      = 0;
  bit          done     = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit ref_q(input bit x, input longint unsigned y, input longint unsigned s);
    return (x & y[0]) ^ s[0];
  endfunction

  function automatic longint unsigned ref_res(input bit x, input longint unsigned y,
                                              input longint unsigned m, input longint unsigned s);
    bit q;
    q = ref_q(x, y, s);
    return (s + (x ? y : 64'd0) + (q ? m : 64'd0)) >> 1;
  endfunction

  // expectation queues, one entry per column
  longint unsigned e_res[$], e_y[$], e_m[$];
  bit              e_x[$], e_q[$], e_b2b[$];
  longint          e_t[$];

  longint unsigned c_res, c_y, c_m;
  bit              c_x, c_q, c_b2b;
  int              widx   = 0;
  bit              in_col = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (out_first) begin
        if (in_col) chk(widx == NUM_WORDS, "R1 words per column", widx, NUM_WORDS);
        if (e_res.size() == 0) begin
          chk(0, "R1 unexpected column", 0, 1);
          in_col = 0;
        end else begin
          c_res = e_res.pop_front(); c_y = e_y.pop_front(); c_m = e_m.pop_front();
          c_x = e_x.pop_front(); c_q = e_q.pop_front(); c_b2b = e_b2b.pop_front();
          begin
            longint t0;
            t0 = e_t.pop_front();
            chk(cyc == t0 + 2, "R5 first word latency", cyc, t0 + 2);
          end
          chk(out_q == c_q, "R2 quotient", out_q, c_q);
          widx   = 0;
          in_col = 1;
        end
      end
      if (in_col) begin
        if (widx >= NUM_WORDS) begin
          chk(0, "R1 extra word", widx, NUM_WORDS);
        end else begin
          longint unsigned es, ey, em;
          es = (c_res >> (widx * WORD_W)) & WMASK;
          ey = (c_y   >> (widx * WORD_W)) & WMASK;
          em = (c_m   >> (widx * WORD_W)) & WMASK;
          chk(64'(out_s) == es, c_b2b ? "R7 back-to-back sum word" : "R4 sum word", out_s, es);
          chk(64'(out_y) == ey && 64'(out_m) == em, "R5 forwarded Y/M", {out_y, out_m}, {ey[WORD_W-1:0], em[WORD_W-1:0]});
          chk(out_x == c_x, "R6 forwarded x", out_x, c_x);
          chk(out_q == c_q, "R2 quotient held", out_q, c_q);
        end
        widx++;
      end
    end
  end

  longint last_word_cyc = -10;

  task automatic send_col(input bit x, input longint unsigned y, input longint unsigned m,
                          input longint unsigned s, input int gap);
    for (int k = 0; k < NUM_WORDS; k++) begin
      @(negedge clk);
      if (k == 0) begin
        e_res.push_back(ref_res(x, y, m, s));
        e_y.push_back(y); e_m.push_back(m); e_x.push_back(x);
        e_q.push_back(ref_q(x, y, s));
        e_b2b.push_back(cyc == last_word_cyc + 1);
        e_t.push_back(cyc);
      end
      in_valid = 1'b1;
      in_first = (k == 0);
      in_x     = (k == 0) ? x : ~x;   // R6: later words carry the wrong x
      in_y     = WORD_W'(y >> (k * WORD_W));
      in_m     = WORD_W'(m >> (k * WORD_W));
      in_s     = WORD_W'(s >> (k * WORD_W));
      last_word_cyc = cyc;
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      in_x = 1'($urandom);
      in_y = WORD_W'($urandom); in_m = WORD_W'($urandom); in_s = WORD_W'($urandom);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    longint unsigned m, y, s;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 0; in_first = 0; in_x = 0; in_y = '0; in_m = '0; in_s = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_first == 0, "R8 reset strobes", {out_valid, out_first}, 0);
    chk(out_s == '0, "R8 reset sum", out_s, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R8 idle after reset", out_valid, 0);

    m = 64'hFFF1;
    send_col(1'b0, 64'd0, m, 64'd0, 0);               // all zero
    send_col(1'b0, 64'd1234, m, 2 * m - 2, 0);        // x=0, q=0: plain halving
    send_col(1'b1, m - 1, m, 2 * m - 1, 0);           // R3: largest carry
    send_col(1'b1, 64'd3, m, 64'd4, 1);               // q forced to 1
    send_col(1'b1, 64'd0, 64'h8001, 64'd1, 2);        // q from S only

    for (int i = 0; i < 80; i++) begin
      m = (64'($urandom) & 64'hFFFF) | 64'h8001;
      y = 64'($urandom) % m;
      s = 64'($urandom) % (2 * m);
      send_col(1'($urandom), y, m, s, int'($urandom % 3));
    end

    @(negedge clk);
    in_valid = 0; in_first = 0;
    repeat (8) @(negedge clk);
    chk(e_res.size() == 0, "R1 all columns returned", e_res.size(), 0);
    chk(widx == NUM_WORDS, "R1 last column length", widx, NUM_WORDS);
    finish_run();
  end

endmodule